// File: doc/BRIEF.md
# Unlock-Command Flash Bank Sequencer

This block erases or programs one bank of a byte-wide parallel flash. The flash accepts a command only after an unlock prefix: fixed bytes written to two magic offsets. It signals an operation in progress by toggling a data bit on each successive read. A single `start` pulse launches an erase or a program of the chosen bank. While the operation runs, `busy` stays high. At the end, a one-cycle `done` pulse appears together with an `error` flag. The flag stays valid until the next accepted start.

An erase sends the two-write unlock and the erase setup, a second unlock, and the confirm command to the bank base. It then polls until the device is idle, issues the device-reset command and reads back every byte, which must be 0xFF. A program handles every byte of the bank in turn. For each byte it sends the unlock and the byte-program command, writes the byte taken from an external buffer, and polls. After the last byte it issues the device reset and compares the whole bank against the buffer. Every command write is followed by a settling wait of `CLK_PER_US` clocks. A poll that never settles gives up after `POLL_LIMIT` attempts.

Top module: `ulk_bank_prog`

## Requirements
- R1: While reset is held, `busy`, `done`, `error`, `fl_we` and `fl_re` are all low.
- R2: An erase of bank b issues exactly these writes, in this order (data at offset from base b*BANK_BYTES): 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x30@0x000, then after polling 0xF0@0x000.
- R3: Each command write is followed by at least `CLK_PER_US` cycles with no bus write. This covers unlock writes, command writes and the 0xF0 reset. The wait after a command write is exactly `CLK_PER_US` cycles, so the next write comes `CLK_PER_US`+1 cycles after it.
- R4: A program of bank b issues, for each byte index i from 0 upward, 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then buffer byte i at offset i. The last byte is followed by 0xF0@0x000.
- R5: Polling reads the bank base twice per attempt and ends when the two reads are equal. The bus never reads and writes in the same cycle.
- R6: If `POLL_LIMIT` attempts all see differing reads, the poll gives up and `error` is raised. A program then stops its byte loop. The 0xF0 reset write is still issued.
- R7: After an erase, bank offsets 0..BANK_BYTES-1 are read back in order, and any byte other than 0xFF raises `error`.
- R8: After a program, the bank is read back and compared with the buffer. Any difference raises `error`, and a clean run reports `error` low.
- R9: `done` is high for exactly one cycle, with `busy` low in that cycle. `error` keeps its value until the next accepted start clears it.
- R10: A `start` pulse while the block is busy is ignored. The running operation's bus sequence is unchanged.
- R11: `bank_sel` picks the base address `bank_sel*BANK_BYTES`. An operation on one bank leaves the other bank's contents untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, sampled while idle |
| op_prog | input | 1 | 0 = erase, 1 = program, captured with start |
| bank_sel | input | 1 | Target bank, captured with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout or verify failure of the last operation |
| buf_addr | output | $clog2(BANK_BYTES) | Buffer read index |
| buf_data | input | 8 | Buffer byte at buf_addr, same cycle |
| fl_addr | output | FL_AW | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid in the cycle of fl_re |

## Verification
The assertions assume the following about the inputs:
- Flash read data and buffer data are combinational, returned in the same cycle as the address.
- `start` is a pulse.
- A data byte can equal 0xA0, so the write-spacing property treats a write that follows an 0xA0 write as a possible program write, which only weakens it.

The bench's flash model always stays busy for an even number of reads, which keeps each poll's read pairs either both toggling or both settled. From the latencies it assigns, the bench can therefore predict the exact read count. Faults are injected only on purpose:
- a stuck-busy device;
- a byte that will not erase;
- a byte that loses a bit when programmed.

// File: rtl/ulk_pkg.sv
package ulk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_CWAIT,
        ST_DATA,
        ST_POLLA,
        ST_POLLB,
        ST_RST,
        ST_RWAIT,
        ST_VFY,
        ST_FIN
    } ulk_state_e;

    localparam int          OFF_W       = 11;
    localparam logic [10:0] OFF_KEY1    = 11'h555;
    localparam logic [10:0] OFF_KEY2    = 11'h2AA;
    localparam logic [7:0]  DAT_KEY1    = 8'hAA;
    localparam logic [7:0]  DAT_KEY2    = 8'h55;
    localparam logic [7:0]  DAT_ERS_SET = 8'h80;
    localparam logic [7:0]  DAT_ERS_GO  = 8'h30;
    localparam logic [7:0]  DAT_PRG     = 8'hA0;
    localparam logic [7:0]  DAT_RESET   = 8'hF0;
    localparam logic [7:0]  DAT_BLANK   = 8'hFF;

endpackage

// File: rtl/ulk_cmd_table.sv
module ulk_cmd_table
    import ulk_pkg::*;
(
    input  logic             prog,
    input  logic [2:0]       step,
    output logic [OFF_W-1:0] off,
    output logic [7:0]       dat,
    output logic             last
);
    always_comb begin
        off  = OFF_KEY1;
        dat  = DAT_KEY1;
        last = 1'b0;
        case (step)
            3'd0: begin off = OFF_KEY1; dat = DAT_KEY1; end
            3'd1: begin off = OFF_KEY2; dat = DAT_KEY2; end
            3'd2: begin
                off  = OFF_KEY1;
                dat  = prog ? DAT_PRG : DAT_ERS_SET;
                last = prog;
            end
            3'd3: begin off = OFF_KEY1; dat = DAT_KEY1; end
            3'd4: begin off = OFF_KEY2; dat = DAT_KEY2; end
            default: begin off = '0; dat = DAT_ERS_GO; last = 1'b1; end
        endcase
    end
endmodule

// File: rtl/ulk_us_timer.sv
module ulk_us_timer #(
    parameter int CLK_PER_US = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expired
);
    localparam int CW = $clog2(CLK_PER_US + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (kick)
            cnt_d = CW'(CLK_PER_US - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ulk_toggle_cmp.sv
module ulk_toggle_cmp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic [7:0] rdata,
    output logic       same
);
    logic [7:0] held_d, held_q;

    always_comb begin
        held_d = capture ? rdata : held_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign same = (rdata == held_q);
endmodule

// File: rtl/ulk_bank_prog.sv
module ulk_bank_prog
    import ulk_pkg::*;
#(
    parameter int BANK_BYTES = 8192,
    parameter int CLK_PER_US = 200,
    parameter int POLL_LIMIT = 1000000,
    parameter int FL_AW      = 14
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          op_prog,
    input  logic                          bank_sel,
    output logic                          busy,
    output logic                          done,
    output logic                          error,
    output logic [$clog2(BANK_BYTES)-1:0] buf_addr,
    input  logic [7:0]                    buf_data,
    output logic [FL_AW-1:0]              fl_addr,
    output logic [7:0]                    fl_wdata,
    output logic                          fl_we,
    output logic                          fl_re,
    input  logic [7:0]                    fl_rdata
);
    localparam int              IDX_W = $clog2(BANK_BYTES);
    localparam int              PC_W  = $clog2(POLL_LIMIT + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BANK_BYTES - 1);
    localparam logic [PC_W-1:0]  PLIM = PC_W'(POLL_LIMIT - 1);

    typedef struct packed {
        ulk_state_e       st;
        logic             prog;
        logic             bank;
        logic [2:0]       step;
        logic [IDX_W-1:0] idx;
        logic [PC_W-1:0]  pcnt;
        logic             err;
    } regs_t;

    regs_t d, q;

    logic             tmr_kick, tmr_exp;
    logic             tog_cap, tog_same;
    logic [OFF_W-1:0] cmd_off;
    logic [7:0]       cmd_dat;
    logic             cmd_last;
    logic [FL_AW-1:0] off_w, base_w;
    logic [7:0]       vfy_exp;

    ulk_cmd_table u_tab (
        .prog (q.prog),
        .step (q.step),
        .off  (cmd_off),
        .dat  (cmd_dat),
        .last (cmd_last)
    );

    ulk_us_timer #(.CLK_PER_US(CLK_PER_US)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (tmr_kick),
        .expired (tmr_exp)
    );

    ulk_toggle_cmp u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (tog_cap),
        .rdata   (fl_rdata),
        .same    (tog_same)
    );

    assign base_w  = q.bank ? FL_AW'(BANK_BYTES) : '0;
    assign vfy_exp = q.prog ? buf_data : DAT_BLANK;

    always_comb begin
        d        = q;
        tmr_kick = 1'b0;
        tog_cap  = 1'b0;
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        off_w    = '0;
        fl_wdata = '0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_CMD;
                    d.prog = op_prog;
                    d.bank = bank_sel;
                    d.step = '0;
                    d.idx  = '0;
                    d.err  = 1'b0;
                end
            end
            ST_CMD: begin
                fl_we    = 1'b1;
                off_w    = FL_AW'(cmd_off);
                fl_wdata = cmd_dat;
                tmr_kick = 1'b1;
                d.st     = ST_CWAIT;
            end
            ST_CWAIT: begin
                if (tmr_exp) begin
                    if (cmd_last) begin
                        d.st   = q.prog ? ST_DATA : ST_POLLA;
                        d.pcnt = '0;
                    end else begin
                        d.step = q.step + 3'd1;
                        d.st   = ST_CMD;
                    end
                end
            end
            ST_DATA: begin
                fl_we    = 1'b1;
                off_w    = FL_AW'(q.idx);
                fl_wdata = buf_data;
                d.pcnt   = '0;
                d.st     = ST_POLLA;
            end
            ST_POLLA: begin
                fl_re   = 1'b1;
                tog_cap = 1'b1;
                d.st    = ST_POLLB;
            end
            ST_POLLB: begin
                fl_re = 1'b1;
                if (tog_same) begin
                    if (q.prog && q.idx != LAST) begin
                        d.idx  = q.idx + 1'b1;
                        d.step = '0;
                        d.st   = ST_CMD;
                    end else begin
                        d.st = ST_RST;
                    end
                end else if (q.pcnt == PLIM) begin
                    d.err = 1'b1;
                    d.st  = ST_RST;
                end else begin
                    d.pcnt = q.pcnt + 1'b1;
                    d.st   = ST_POLLA;
                end
            end
            ST_RST: begin
                fl_we    = 1'b1;
                fl_wdata = DAT_RESET;
                tmr_kick = 1'b1;
                d.st     = ST_RWAIT;
            end
            ST_RWAIT: begin
                if (tmr_exp) begin
                    d.idx = '0;
                    d.st  = ST_VFY;
                end
            end
            ST_VFY: begin
                fl_re = 1'b1;
                off_w = FL_AW'(q.idx);
                if (fl_rdata != vfy_exp) begin
                    d.err = 1'b1;
                    d.st  = ST_FIN;
                end else if (q.idx == LAST) begin
                    d.st = ST_FIN;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_FIN:  d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.prog <= 1'b0;
            q.bank <= 1'b0;
            q.step <= '0;
            q.idx  <= '0;
            q.pcnt <= '0;
            q.err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign fl_addr  = base_w + off_w;
    assign buf_addr = q.idx;
    assign busy     = (q.st != ST_IDLE) && (q.st != ST_FIN);
    assign done     = (q.st == ST_FIN);
    assign error    = q.err;

endmodule

// File: rtl/ulk_bank_prog_chk.sv
module ulk_bank_prog_chk #(
    parameter int CLK_PER_US = 200,
    parameter int FL_AW      = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic             fl_we,
    input logic             fl_re,
    input logic [7:0]       fl_wdata,
    input logic [FL_AW-1:0] fl_addr
);
    localparam int GW = $clog2(CLK_PER_US + 1) + 1;

    logic [GW-1:0] gap_q;
    logic [1:0]    wcnt_q;
    logic [7:0]    wd1_q, wd2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            wcnt_q <= '0;
            wd1_q  <= '0;
            wd2_q  <= '0;
        end else if (fl_we) begin
            gap_q  <= '0;
            wcnt_q <= (wcnt_q == 2'd2) ? 2'd2 : wcnt_q + 2'd1;
            wd1_q  <= fl_wdata;
            wd2_q  <= wd1_q;
        end else if (gap_q < GW'(CLK_PER_US)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!busy && !done && !error && !fl_we && !fl_re)
                else $error("outputs active during reset");
        end
    end

    p_bus_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    // R3: a write that does not follow a program-data write keeps the settle gap
    p_cmd_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we && wcnt_q != 2'd0 && !(wcnt_q == 2'd2 && wd2_q == 8'hA0))
        |-> (gap_q >= GW'(CLK_PER_US)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(error));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

endmodule

bind ulk_bank_prog ulk_bank_prog_chk #(
    .CLK_PER_US (CLK_PER_US),
    .FL_AW      (FL_AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .fl_we    (fl_we),
    .fl_re    (fl_re),
    .fl_wdata (fl_wdata),
    .fl_addr  (fl_addr)
);

// File: tb/ulk_bank_prog_tb.sv
module ulk_bank_prog_tb;
    localparam int BANK  = 32;
    localparam int US    = 4;
    localparam int PL    = 16;
    localparam int AW    = 14;
    localparam int IW    = $clog2(BANK);
    localparam int STUCK = 1000000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, op_prog = 1'b0, bank_sel = 1'b0;
    logic busy, done, error, fl_we, fl_re;
    logic [IW-1:0] buf_addr;
    logic [7:0] buf_data, fl_wdata, fl_rdata;
    logic [AW-1:0] fl_addr;

    always #2.5 clk = ~clk;

    ulk_bank_prog #(.BANK_BYTES(BANK), .CLK_PER_US(US), .POLL_LIMIT(PL), .FL_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .bank_sel(bank_sel),
        .busy(busy), .done(done), .error(error), .buf_addr(buf_addr), .buf_data(buf_data),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural flash and buffer ----------------
    logic [7:0] fmem [0:2*BANK-1];
    logic [7:0] bufm [0:BANK-1];
    logic [AW-1:0] wl_a [0:255];
    logic [7:0]    wl_d [0:255];
    int ucyc = 0, busy_left = 0, stuck = 0, lat_mode = -1;
    int erase_bad = -1, prog_bad = -1;
    int n_wr = 0, n_reads = 0, n_data = 0, busy_sum = 0, min_gap = 0, rd_at_rst = -1;
    int cyc = 0, last_wr_cyc = 0;
    bit last_was_cmd = 1'b0;
    logic tog = 1'b0;

    assign buf_data = bufm[buf_addr];
    assign fl_rdata = (busy_left > 0) ? (8'h0B ^ {1'b0, tog, 6'b0})
                    : ((int'(fl_addr) < 2*BANK) ? fmem[int'(fl_addr)] : 8'hFF);

    function automatic bit is_off(input int a, input int o);
        return (a == o) || (a == BANK + o);
    endfunction

    function automatic int next_lat();
        if (stuck != 0) return STUCK;
        if (lat_mode >= 0) return lat_mode;
        return 2 * int'($urandom % 4);
    endfunction

    always @(posedge clk) begin
        int a;
        int lat;
        cyc <= cyc + 1;
        if (fl_re) begin
            n_reads <= n_reads + 1;
            if (busy_left > 0) begin
                tog <= ~tog;
                if (stuck == 0) busy_left <= busy_left - 1;
            end
        end
        if (fl_we) begin
            a = int'(fl_addr);
            if (n_wr < 256) begin
                wl_a[n_wr] <= fl_addr;
                wl_d[n_wr] <= fl_wdata;
            end
            n_wr <= n_wr + 1;
            if (n_wr > 0 && last_was_cmd && (cyc - last_wr_cyc) < min_gap)
                min_gap <= cyc - last_wr_cyc;
            last_wr_cyc  <= cyc;
            last_was_cmd <= (ucyc != 3);
            if (ucyc == 3) begin
                lat = next_lat();
                if (a < 2*BANK)
                    fmem[a] <= ((a % BANK) == prog_bad) ? (fl_wdata & fmem[a] & 8'hFE)
                                                        : (fl_wdata & fmem[a]);
                busy_left <= lat;
                busy_sum  <= busy_sum + lat;
                n_data    <= n_data + 1;
                ucyc      <= 0;
            end else if (fl_wdata == 8'hF0) begin
                ucyc      <= 0;
                rd_at_rst <= n_reads;
            end else begin
                case (ucyc)
                    0: ucyc <= (fl_wdata == 8'hAA && is_off(a, 'h555)) ? 1 : 0;
                    1: ucyc <= (fl_wdata == 8'h55 && is_off(a, 'h2AA)) ? 2 : 0;
                    2: ucyc <= (fl_wdata == 8'hA0 && is_off(a, 'h555)) ? 3 :
                               (fl_wdata == 8'h80 && is_off(a, 'h555)) ? 4 : 0;
                    4: ucyc <= (fl_wdata == 8'hAA && is_off(a, 'h555)) ? 5 : 0;
                    5: ucyc <= (fl_wdata == 8'h55 && is_off(a, 'h2AA)) ? 6 : 0;
                    6: begin
                        if (fl_wdata == 8'h30 && (a == 0 || a == BANK)) begin
                            lat = next_lat();
                            for (int k = 0; k < BANK; k++)
                                fmem[a + k] <= (k == erase_bad) ? 8'h00 : 8'hFF;
                            busy_left <= lat;
                            busy_sum  <= busy_sum + lat;
                        end
                        ucyc <= 0;
                    end
                    default: ucyc <= 0;
                endcase
            end
        end
    end

    // ---------------- helpers ----------------
    bit op_err, busy_at_done, done_after, op_timeout;

    task automatic run_op(input bit p, input bit b, input int poke);
        int t;
        n_wr = 0; n_reads = 0; n_data = 0; busy_sum = 0; min_gap = 1 << 30; rd_at_rst = -1;
        @(negedge clk);
        op_prog = p; bank_sel = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (poke > 0) begin
                start = (t == poke);
                op_prog = ~p; bank_sel = ~b;
            end
        end
        start = 1'b0;
        op_timeout = (t >= 20000);
        op_err = error;
        busy_at_done = busy;
        @(negedge clk);
        done_after = done;
        chk(!op_timeout, "R9 op completes", t, 0);
    endtask

    function automatic bit seq_ok(input bit p, input int b);
        int n_exp, ea, ed, base;
        base  = b * BANK;
        n_exp = p ? 4*BANK + 1 : 7;
        if (n_wr != n_exp) return 1'b0;
        for (int k = 0; k < n_exp; k++) begin
            if (k == n_exp - 1) begin
                ea = 0; ed = 'hF0;
            end else if (p) begin
                case (k % 4)
                    0: begin ea = 'h555; ed = 'hAA; end
                    1: begin ea = 'h2AA; ed = 'h55; end
                    2: begin ea = 'h555; ed = 'hA0; end
                    default: begin ea = k / 4; ed = int'(bufm[k / 4]); end
                endcase
            end else begin
                case (k)
                    0: begin ea = 'h555; ed = 'hAA; end
                    1: begin ea = 'h2AA; ed = 'h55; end
                    2: begin ea = 'h555; ed = 'h80; end
                    3: begin ea = 'h555; ed = 'hAA; end
                    4: begin ea = 'h2AA; ed = 'h55; end
                    default: begin ea = 0; ed = 'h30; end
                endcase
            end
            if (int'(wl_a[k]) != base + ea || int'(wl_d[k]) != ed) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic int bank_not_ff(input int b);
        int n = 0;
        for (int k = 0; k < BANK; k++) if (fmem[b*BANK + k] != 8'hFF) n++;
        return n;
    endfunction

    function automatic int bank_diff(input int b);
        int n = 0;
        for (int k = 0; k < BANK; k++) if (fmem[b*BANK + k] != bufm[k]) n++;
        return n;
    endfunction

    task automatic fill_buf();
        for (int k = 0; k < BANK; k++) bufm[k] = 8'($urandom);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] snap [0:BANK-1];
        int diff;
        void'($urandom(32'd1234));
        for (int k = 0; k < 2*BANK; k++) fmem[k] = 8'h00;
        for (int k = 0; k < BANK; k++) bufm[k] = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !error, "R1 status in reset", {busy, done, error}, 0);
        chk(!fl_we && !fl_re, "R1 bus idle in reset", {fl_we, fl_re}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // erase bank 0, random even latencies
        run_op(1'b0, 1'b0, 0);
        chk(!op_err, "R7 clean erase error", op_err, 0);
        chk(seq_ok(1'b0, 0), "R2 erase write sequence", n_wr, 7);
        chk(min_gap == US + 1, "R3 command spacing erase", min_gap, US + 1);
        chk(bank_not_ff(0) == 0, "R7 bank0 blank", bank_not_ff(0), 0);
        chk(n_reads == busy_sum + 2 + BANK, "R5 erase read count", n_reads, busy_sum + 2 + BANK);

        // program bank 0
        fill_buf();
        run_op(1'b1, 1'b0, 0);
        chk(!op_err, "R8 clean program error", op_err, 0);
        chk(seq_ok(1'b1, 0), "R4 program write sequence", n_wr, 4*BANK + 1);
        chk(min_gap == US + 1, "R3 command spacing program", min_gap, US + 1);
        chk(bank_diff(0) == 0, "R8 bank0 content", bank_diff(0), 0);
        chk(n_reads == busy_sum + 2*BANK + BANK, "R5 program read count", n_reads, busy_sum + 3*BANK);
        chk(!busy_at_done, "R9 busy low at done", busy_at_done, 0);
        chk(!done_after, "R9 done one cycle", done_after, 0);

        // R11 bank 1 erase and program, bank 0 untouched
        for (int k = 0; k < BANK; k++) snap[k] = fmem[k];
        run_op(1'b0, 1'b1, 0);
        chk(seq_ok(1'b0, 1), "R11 erase addresses bank1", n_wr, 7);
        fill_buf();
        run_op(1'b1, 1'b1, 0);
        chk(seq_ok(1'b1, 1) && !op_err, "R11 program bank1", op_err, 0);
        diff = 0;
        for (int k = 0; k < BANK; k++) if (fmem[k] != snap[k]) diff++;
        chk(diff == 0, "R11 bank0 untouched", diff, 0);

        // R10 start while busy is ignored
        run_op(1'b0, 1'b0, 12);
        chk(n_wr == 7 && !op_err, "R10 restart ignored", n_wr, 7);
        chk(bank_not_ff(1) != 0, "R10 bank1 not erased", bank_not_ff(1), 1);

        // R6 stuck during erase
        stuck = 1;
        run_op(1'b0, 1'b0, 0);
        chk(op_err, "R6 erase timeout error", op_err, 1);
        chk(rd_at_rst == 2*PL, "R6 poll attempts", rd_at_rst, 2*PL);
        chk(wl_d[n_wr-1] == 8'hF0, "R6 reset after timeout", wl_d[n_wr-1], 'hF0);
        repeat (5) @(negedge clk);
        chk(error, "R9 error held", error, 1);
        stuck = 0; busy_left = 0; lat_mode = 0;

        // R7 blank check failure
        erase_bad = 3;
        @(negedge clk);
        op_prog = 1'b0; bank_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!error, "R9 error cleared on start", error, 0);
        while (!done) @(negedge clk);
        chk(error, "R7 unerased byte error", error, 1);
        @(negedge clk);
        erase_bad = -1;

        // R6 stuck during program: loop stops after first byte
        run_op(1'b0, 1'b0, 0);
        fill_buf();
        stuck = 1;
        run_op(1'b1, 1'b0, 0);
        chk(op_err, "R6 program timeout error", op_err, 1);
        chk(n_data == 1, "R6 program stops early", n_data, 1);
        stuck = 0; busy_left = 0;

        // R8 readback mismatch
        run_op(1'b0, 1'b0, 0);
        fill_buf();
        bufm[5] = 8'hFF;
        prog_bad = 5;
        run_op(1'b1, 1'b0, 0);
        chk(op_err, "R8 mismatch error", op_err, 1);
        prog_bad = -1;

        // random sweeps
        lat_mode = -1;
        for (int it = 0; it < 3; it++) begin
            bit b;
            b = 1'($urandom);
            run_op(1'b0, b, 0);
            fill_buf();
            if (it == 0) begin
                bufm[0] = 8'h00;
                bufm[BANK-1] = 8'hF0;
            end
            run_op(1'b1, b, 0);
            chk(!op_err && bank_diff(int'(b)) == 0, "R8 random program", bank_diff(int'(b)), 0);
            chk(seq_ok(1'b1, int'(b)), "R4 random sequence", n_wr, 4*BANK + 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule